// File: doc/BRIEF.md
# Serial CRC Generator and Checker

This block computes a cyclic redundancy check one bit per clock. A shift register with XOR feedback divides the incoming bit stream by a generator polynomial that is fixed by a parameter. The bits arrive most significant first. When the final bit of a message has been taken in, the block presents the remainder. The sender places that remainder after the message, and a receiver runs the whole frame through the same block. A zero remainder tells the receiver that the frame is intact.

Two forms of the divider are available, selected by a parameter. The augmented form behaves as if n zero bits had been appended to the message, so its remainder is ready directly after the last message bit. The direct form performs plain long division, so the caller shifts in the n zero bits itself. A preload parameter sets the register value at the start of a message: zero for textbook division, or all ones as the 32-bit Ethernet-style check uses. A first-bit marker restarts the division from that preload, and a last-bit marker closes the message. The result appears one clock after the last bit.

Top module: `crc_serial_engine`

## Requirements
- R1: While `i_clr` is high at a clock edge, the register is loaded with the preload value and `o_valid`, `o_rem` and `o_crc_ok` are all 0 after that edge.
- R2: When `i_clr` and `i_valid` are both high in the same cycle, the clear wins and the offered bit is discarded.
- R3: A cycle with `i_valid` low leaves the division state unchanged, whatever `i_bit`, `i_first` and `i_last` carry.
- R4: An accepted bit with `i_first` high is divided into the preload value, and any partial state from earlier bits is dropped.
- R5: In the augmented form (FORM = FORM_AUGMENTED, the default), after the bits of message M arrive MSB first, `o_rem` equals M·x^n mod G. For G = x^4+x+1 and M = 1011001 this gives 1010.
- R6: In the direct form (FORM = FORM_DIRECT), `o_rem` equals the shifted bit string itself mod G. Shifting M followed by n zeros therefore gives the same remainder as R5.
- R7: Check mode uses the same divider. A frame made of the message followed by its remainder (10110011010 in the example) gives `o_rem` = 0 and `o_crc_ok` = 1. Any single flipped bit gives `o_crc_ok` = 0.
- R8: `o_valid` is high for exactly the one cycle after an accepted bit with `i_last` high. `o_rem` and `o_crc_ok` hold their values until the next result.
- R9: For WIDTH=32, G = 0x04C11DB7 (the low coefficients, x^32 implied) and an all-ones preload, with no reflection and no final XOR, the ASCII bytes "123456789" sent MSB first give the remainder 0x0376E6E7. That frame followed by those 32 bits gives 0.
- R10: For WIDTH=16, G = 0x8005 (x^16+x^15+x^2+1) and a zero preload, "123456789" gives the remainder 0xFEE8.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| i_clk | input | 1 | Clock |
| i_clr | input | 1 | Synchronous clear, active high |
| i_valid | input | 1 | Qualifies `i_bit`, `i_first` and `i_last` |
| i_bit | input | 1 | Serial data bit, MSB first |
| i_first | input | 1 | Marks the first bit of a message; restarts from the preload |
| i_last | input | 1 | Marks the final bit; the result follows one cycle later |
| o_rem | output | WIDTH | Remainder captured at the last bit |
| o_crc_ok | output | 1 | High when the captured remainder is zero |
| o_valid | output | 1 | One-cycle pulse when a new result is present |

## Verification
A single wrong feedback tap or a wrong shift-in position damages the remainder only for particular bit patterns. The bench therefore sweeps every 7-bit message through both divider forms of the 4-bit configuration and compares each result against arithmetic long division. A state corruption that occurs mid-message is never visible until the cycle after the last bit. At that point `o_rem` differs from the expected value, and a good frame is reported as bad. Errors in the preload or the first-bit restart show up only on the all-ones preload or after an abandoned partial message, so both cases are driven on purpose. Timing faults in the result capture appear as an `o_valid` pulse that comes early or is missing, or as `o_rem` changing between results.

// File: rtl/crc_serial_pkg.sv
package crc_serial_pkg;

   // Which flavour of the divider is built.
   // AUGMENTED: message bit enters at the feedback point (implicit n zero bits).
   // DIRECT   : message bit enters at stage 0 (caller supplies the n zero bits).
   typedef enum logic {
      FORM_AUGMENTED = 1'b0,
      FORM_DIRECT    = 1'b1
   } crc_form_e;

endpackage

// File: rtl/crc_feedback.sv
module crc_feedback #(
   parameter int                     WIDTH = 4,
   parameter crc_serial_pkg::crc_form_e FORM = crc_serial_pkg::FORM_AUGMENTED
) (
   input  logic [WIDTH-1:0] base,
   input  logic             din,
   output logic             fb,
   output logic             low_in
);

   generate
      if (FORM == crc_serial_pkg::FORM_AUGMENTED) begin : g_aug
         // top bit and incoming bit combine before deciding on the subtraction
         always_comb begin
            fb     = base[WIDTH-1] ^ din;
            low_in = 1'b0;
         end
      end else begin : g_direct
         // plain long division: new bit enters at the bottom
         always_comb begin
            fb     = base[WIDTH-1];
            low_in = din;
         end
      end
   endgenerate

endmodule

// File: rtl/crc_shift_core.sv
module crc_shift_core #(
   parameter int                        WIDTH = 4,
   parameter logic [WIDTH-1:0]          POLY  = 'h3,
   parameter logic [WIDTH-1:0]          INIT  = '0,
   parameter crc_serial_pkg::crc_form_e FORM  = crc_serial_pkg::FORM_AUGMENTED
) (
   input  logic             clk,
   input  logic             clr,
   input  logic             en,
   input  logic             first,
   input  logic             din,
   output logic [WIDTH-1:0] state,
   output logic [WIDTH-1:0] next
);

   logic [WIDTH-1:0] base;
   logic             fb;
   logic             low_in;

   // a first-marked bit divides into the preload, not the running state
   assign base = first ? INIT : state;

   crc_feedback #(
      .WIDTH (WIDTH),
      .FORM  (FORM)
   ) u_fb (
      .base   (base),
      .din    (din),
      .fb     (fb),
      .low_in (low_in)
   );

   // one stage per register bit; a tap exists where the polynomial has a term
   generate
      for (genvar s = 0; s < WIDTH; s++) begin : g_stage
         if (s == 0) begin : g_bottom
            if (POLY[0]) begin : g_tap
               assign next[0] = low_in ^ fb;
            end else begin : g_plain
               assign next[0] = low_in;
            end
         end else begin : g_upper
            if (POLY[s]) begin : g_tap
               assign next[s] = base[s-1] ^ fb;
            end else begin : g_plain
               assign next[s] = base[s-1];
            end
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (clr) begin
         state <= INIT;
      end else if (en) begin
         state <= next;
      end
   end

endmodule

// File: rtl/crc_result_hold.sv
module crc_result_hold #(
   parameter int WIDTH = 4
) (
   input  logic             clk,
   input  logic             clr,
   input  logic             capture,
   input  logic [WIDTH-1:0] value,
   output logic [WIDTH-1:0] rem,
   output logic             zero,
   output logic             pulse
);

   always_ff @(posedge clk) begin
      if (clr) begin
         rem   <= '0;
         zero  <= 1'b0;
         pulse <= 1'b0;
      end else begin
         pulse <= capture;
         if (capture) begin
            rem  <= value;
            zero <= ~|value;
         end
      end
   end

endmodule

// File: rtl/crc_serial_engine.sv
module crc_serial_engine #(
   parameter int                        WIDTH = 4,
   parameter logic [WIDTH-1:0]          POLY  = 'h3,
   parameter logic [WIDTH-1:0]          INIT  = '0,
   parameter crc_serial_pkg::crc_form_e FORM  = crc_serial_pkg::FORM_AUGMENTED
) (
   input  logic             i_clk,
   input  logic             i_clr,
   input  logic             i_valid,
   input  logic             i_bit,
   input  logic             i_first,
   input  logic             i_last,
   output logic [WIDTH-1:0] o_rem,
   output logic             o_crc_ok,
   output logic             o_valid
);

   localparam int TAP_COUNT = $countones(POLY);

   // elaboration-time sanity of the configuration
   generate
      if (WIDTH < 2) begin : g_bad_width
         $error("crc_serial_engine: WIDTH must be at least 2");
      end
      if (!POLY[0]) begin : g_bad_poly
         $error("crc_serial_engine: generator must contain the x^0 term");
      end
      if (TAP_COUNT < 1) begin : g_no_taps
         $error("crc_serial_engine: generator has no low-order terms");
      end
   endgenerate

   logic [WIDTH-1:0] core_state;
   logic [WIDTH-1:0] core_next;
   logic             accept;
   logic             close;

   // clear outranks a bit offered in the same cycle
   assign accept = i_valid & ~i_clr;
   assign close  = accept & i_last;

   crc_shift_core #(
      .WIDTH (WIDTH),
      .POLY  (POLY),
      .INIT  (INIT),
      .FORM  (FORM)
   ) u_core (
      .clk   (i_clk),
      .clr   (i_clr),
      .en    (accept),
      .first (i_first),
      .din   (i_bit),
      .state (core_state),
      .next  (core_next)
   );

   crc_result_hold #(
      .WIDTH (WIDTH)
   ) u_hold (
      .clk     (i_clk),
      .clr     (i_clr),
      .capture (close),
      .value   (core_next),
      .rem     (o_rem),
      .zero    (o_crc_ok),
      .pulse   (o_valid)
   );

endmodule

// File: rtl/crc_serial_checker.sv
module crc_serial_checker #(
   parameter int               WIDTH = 4,
   parameter logic [WIDTH-1:0] INIT  = '0
) (
   input logic             clk,
   input logic             clr,
   input logic             in_valid,
   input logic             in_last,
   input logic [WIDTH-1:0] state,
   input logic [WIDTH-1:0] rem,
   input logic             ok,
   input logic             vld
);

   // R1: outputs are quiet right after a clear
   a_r1_clear_outputs : assert property (@(posedge clk) disable iff (clr)
      $past(clr) |-> (!vld && rem == '0 && !ok));

   // R2: a clear cycle leaves the register at the preload even with a bit offered
   a_r2_clear_wins : assert property (@(posedge clk) disable iff (clr)
      $past(clr) |-> state == INIT);

   // R3: no accepted bit, no state change
   a_r3_idle_holds_state : assert property (@(posedge clk) disable iff (clr)
      !in_valid |=> $stable(state));

   // R8: result pulse follows the last bit by one cycle
   a_r8_valid_after_last : assert property (@(posedge clk) disable iff (clr)
      (in_valid && in_last) |=> vld);

   // R8: no pulse without a last bit before it
   a_r8_valid_only_after_last : assert property (@(posedge clk) disable iff (clr)
      vld |-> $past(in_valid && in_last && !clr));

   // R8: result holds between pulses
   a_r8_hold_result : assert property (@(posedge clk) disable iff (clr)
      (!vld && !$past(clr)) |-> ($stable(rem) && $stable(ok)));

   // R7: the good-frame flag agrees with the presented remainder
   a_r7_ok_matches_rem : assert property (@(posedge clk) disable iff (clr)
      vld |-> (ok == (rem == '0)));

endmodule

bind crc_serial_engine crc_serial_checker #(
   .WIDTH (WIDTH),
   .INIT  (INIT)
) u_chk (
   .clk      (i_clk),
   .clr      (i_clr),
   .in_valid (i_valid),
   .in_last  (i_last),
   .state    (core_state),
   .rem      (o_rem),
   .ok       (o_crc_ok),
   .vld      (o_valid)
);

// File: tb/sim_crc_serial_engine.sv
module sim_crc_serial_engine;

   logic       clk = 1'b0;
   logic       clr = 1'b1;
   logic       v [4];
   logic       d [4];
   logic       f [4];
   logic       l [4];
   logic [3:0]  rem0, rem1;
   logic [31:0] rem2;
   logic [15:0] rem3;
   logic        ok [4];
   logic        vld [4];

   int n_chk = 0;
   int n_err = 0;

   always #10 clk = ~clk;   // 50 MHz

   crc_serial_engine #(.WIDTH(4), .POLY(4'h3), .INIT(4'h0),
      .FORM(crc_serial_pkg::FORM_AUGMENTED)) u0 (
      .i_clk(clk), .i_clr(clr), .i_valid(v[0]), .i_bit(d[0]), .i_first(f[0]),
      .i_last(l[0]), .o_rem(rem0), .o_crc_ok(ok[0]), .o_valid(vld[0]));

   crc_serial_engine #(.WIDTH(4), .POLY(4'h3), .INIT(4'h0),
      .FORM(crc_serial_pkg::FORM_DIRECT)) u1 (
      .i_clk(clk), .i_clr(clr), .i_valid(v[1]), .i_bit(d[1]), .i_first(f[1]),
      .i_last(l[1]), .o_rem(rem1), .o_crc_ok(ok[1]), .o_valid(vld[1]));

   crc_serial_engine #(.WIDTH(32), .POLY(32'h04C11DB7), .INIT(32'hFFFFFFFF),
      .FORM(crc_serial_pkg::FORM_AUGMENTED)) u2 (
      .i_clk(clk), .i_clr(clr), .i_valid(v[2]), .i_bit(d[2]), .i_first(f[2]),
      .i_last(l[2]), .o_rem(rem2), .o_crc_ok(ok[2]), .o_valid(vld[2]));

   crc_serial_engine #(.WIDTH(16), .POLY(16'h8005), .INIT(16'h0000),
      .FORM(crc_serial_pkg::FORM_AUGMENTED)) u3 (
      .i_clk(clk), .i_clr(clr), .i_valid(v[3]), .i_bit(d[3]), .i_first(f[3]),
      .i_last(l[3]), .o_rem(rem3), .o_crc_ok(ok[3]), .o_valid(vld[3]));

   task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_err++;
         $display("FAIL %s: got %0h expected %0h", tag, got, exp);
      end
   endtask

   // binary long division of val (nbits wide) by gen of degree deg
   function automatic logic [63:0] lmod(input logic [63:0] val, input int nbits,
                                        input logic [63:0] gen, input int deg);
      logic [63:0] r = val;
      for (int i = nbits - 1; i >= deg; i--)
         if (r[i]) r = r ^ (gen << (i - deg));
      return r & ((64'd1 << deg) - 1);
   endfunction

   // drive n bits MSB first on engine k; ends at the negedge after the last edge
   task automatic shift(input int k, input logic [63:0] bits, input int n,
                        input bit mark_first, input bit mark_last, input bit gaps);
      for (int i = n - 1; i >= 0; i--) begin
         @(negedge clk);
         v[k] = 1'b1; d[k] = bits[i];
         f[k] = mark_first && (i == n - 1);
         l[k] = mark_last && (i == 0);
         if (gaps && i != 0) begin
            @(negedge clk);
            // idle cycle with noise on the other inputs
            v[k] = 1'b0; d[k] = ~bits[i]; f[k] = 1'b1; l[k] = 1'b1;
         end
      end
      @(negedge clk);
      v[k] = 1'b0; d[k] = 1'b0; f[k] = 1'b0; l[k] = 1'b0;
   endtask

   function automatic logic [7:0] digit(input int b);
      return 8'h31 + 8'(b);
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      n_err++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      logic [3:0]  ex;
      logic [10:0] frame;
      logic [3:0]  held;
      for (int k = 0; k < 4; k++) begin
         v[k] = 1'b0; d[k] = 1'b0; f[k] = 1'b0; l[k] = 1'b0;
      end
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R1: reset state
      check("R1 valid after clear", {63'd0, vld[0]}, 64'd0);
      check("R1 rem after clear", {60'd0, rem0}, 64'd0);
      check("R1 ok after clear", {63'd0, ok[0]}, 64'd0);
      clr = 1'b0;

      // R5: worked example, augmented form
      shift(0, 64'b1011001, 7, 1, 1, 0);
      check("R8 valid pulse", {63'd0, vld[0]}, 64'd1);
      check("R5 example remainder", {60'd0, rem0}, 64'b1010);
      held = rem0;
      @(negedge clk);
      check("R8 pulse one cycle", {63'd0, vld[0]}, 64'd0);
      check("R8 remainder held", {60'd0, rem0}, {60'd0, held});
      // R7: example frame
      shift(0, 64'b10110011010, 11, 1, 1, 0);
      check("R7 example frame rem", {60'd0, rem0}, 64'd0);
      check("R7 example frame ok", {63'd0, ok[0]}, 64'd1);

      // R3: idle cycles with noisy inputs between bits
      shift(0, 64'b1011001, 7, 1, 1, 1);
      check("R3 gaps ignored", {60'd0, rem0}, 64'b1010);

      // R4: abandoned partial message, then restart
      shift(0, 64'b111, 3, 1, 0, 0);
      shift(0, 64'b1011001, 7, 1, 1, 0);
      check("R4 first restarts", {60'd0, rem0}, 64'b1010);

      // R2: clear together with a bit offered
      shift(0, 64'b110, 3, 1, 0, 0);
      @(negedge clk);
      clr = 1'b1; v[0] = 1'b1; d[0] = 1'b1;
      @(negedge clk);
      clr = 1'b0; v[0] = 1'b0; d[0] = 1'b0;
      check("R1 rem after mid clear", {60'd0, rem0}, 64'd0);
      shift(0, 64'b1011001, 7, 0, 1, 0);
      check("R2 clear wins over bit", {60'd0, rem0}, 64'b1010);

      // exhaustive sweep over 7-bit messages, both forms
      for (int m = 0; m < 128; m++) begin
         ex = 4'(lmod(64'(m) << 4, 11, 64'b10011, 4));
         frame = {7'(m), ex};
         shift(0, 64'(m), 7, 1, 1, 0);
         check("R5 sweep rem", {60'd0, rem0}, {60'd0, ex});
         check("R7 sweep ok flag", {63'd0, ok[0]}, {63'd0, ex == 4'd0});
         shift(0, 64'(frame), 11, 1, 1, 0);
         check("R7 sweep good frame", {63'd0, ok[0]}, 64'd1);
         shift(0, 64'(frame ^ (11'd1 << (m % 11))), 11, 1, 1, 0);
         check("R7 sweep bit error", {63'd0, ok[0]}, 64'd0);
         shift(1, 64'(m) << 4, 11, 1, 1, 0);
         check("R6 direct sweep rem", {60'd0, rem1}, {60'd0, ex});
         shift(1, 64'(frame), 11, 1, 1, 0);
         check("R6 direct frame rem", {60'd0, rem1}, 64'd0);
      end

      // R9: 32-bit check value with all-ones preload
      for (int b = 0; b < 9; b++)
         shift(2, 64'(digit(b)), 8, b == 0, b == 8, 0);
      check("R9 crc32 check value", {32'd0, rem2}, 64'h0376E6E7);
      for (int b = 0; b < 13; b++)
         shift(2, (b < 9) ? 64'(digit(b)) : 64'((32'h0376E6E7 >> (8 * (12 - b))) & 32'hFF),
               8, b == 0, b == 12, 0);
      check("R9 crc32 frame rem", {32'd0, rem2}, 64'd0);
      check("R9 crc32 frame ok", {63'd0, ok[2]}, 64'd1);

      // R10: 16-bit check value
      for (int b = 0; b < 9; b++)
         shift(3, 64'(digit(b)), 8, b == 0, b == 8, 0);
      check("R10 crc16 check value", {48'd0, rem3}, 64'hFEE8);

      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

endmodule